// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a first-level cache for a processor. It is direct-mapped: each line address maps to one slot, chosen by the low address bits. A small fully-associative victim buffer sits between the cache array and the refill path. Whenever a valid line is pushed out of the direct-mapped array by a miss, that line moves into the victim buffer. The line that was requested never goes into the buffer. In this version a cache line is one data word.

On a miss in the primary array, all victim entries are compared with the request in parallel. On a victim hit, the victim entry and the primary line at that index trade places, and the access completes one cycle later with no traffic to the next memory level. On a miss in both:

- the block sends a refill request, with one request outstanding at a time;
- the processor port stays stalled until the response arrives;
- a dirty line dropped from the victim buffer leaves through a one-cycle writeback port.

Top module: `victim_backed_cache`

## Requirements
- R1: A read that hits the primary array raises `cpu_ready` in the same cycle the request is presented, with the stored word on `cpu_rdata`.
- R2: A write that hits stores `cpu_wdata`, and later reads of that address return the written word for as long as the line stays in the cache or the victim buffer.
- R3: A request that misses the primary array but hits the victim buffer completes exactly one cycle after it is presented, and issues no refill request.
- R4: After a victim hit, the requested line is in the primary array and the displaced primary line is in the victim buffer; no line address is held twice.
- R5: A miss in both stores issues exactly one refill request, carrying the request's address. `cpu_ready` stays low until the refill response has been written, and the request then completes.
- R6: On a miss in both stores, a valid line displaced from the primary array is inserted into the victim buffer; the requested line is not.
- R7: An insertion goes to an invalid victim entry if there is one. When the buffer is full, it replaces the least recently inserted or swapped-in entry.
- R8: A dirty line dropped from the victim buffer appears on the writeback port as a single-cycle `wb_valid` pulse with its address and data. Clean lines produce no pulse.
- R9: Reset invalidates every line in both stores, so the first access to any address after reset is a miss in both stores.
- R10: The number of victim entries is a parameter, `VICTIMS`, that may take any value from 1 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| cpu_valid | input | 1 | Processor request present; held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line (word) address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | The request completes at this clock edge |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ready` is high |
| mem_req_valid | output | 1 | Refill request to the next level |
| mem_req_ready | input | 1 | The next level accepts the refill request |
| mem_req_addr | output | ADDR_W | Line address to refill |
| mem_resp_valid | input | 1 | Refill data present |
| mem_resp_data | input | DATA_W | Refill data |
| wb_valid | output | 1 | Single-cycle pulse: a dirty line leaves the victim buffer |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_data | output | DATA_W | Data of the written-back line |

## Verification
The hardest case to reach is a full victim buffer whose least recently used entry is dirty, just as a further conflicting miss arrives. Reaching it needs at least VICTIMS+2 live lines that map to one index, with the right dirty bits. The stimulus drives chains of writes and reads to a single index. It then re-touches an older victim entry through a victim hit, so that the replacement order differs from the insertion order. A reference model of both stores predicts, for every access, whether it is a primary hit, a victim hit or a full miss. It also predicts which line leaves on the writeback port, so latency, refill traffic and writeback traffic are all compared against it. A mixed pseudo-random phase over a few indices follows.

// File: rtl/vcache_pkg.sv
package vcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/vc_line_array.sv
module vc_line_array #(
  parameter int SETS   = 16,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   valid_q, valid_d;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      dirty_q[wr_idx] <= wr_dirty;
      tag_q[wr_idx]   <= wr_tag;
      data_q[wr_idx]  <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/vc_age_lru.sv
module vc_age_lru #(
  parameter int ENTRIES = 4,
  parameter int SLOT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch_en,
  input  logic [SLOT_W-1:0] touch_slot,
  output logic [SLOT_W-1:0] lru_slot
);
  localparam logic [SLOT_W-1:0] OLDEST = SLOT_W'(ENTRIES - 1);

  logic [SLOT_W-1:0] age_q [ENTRIES];
  logic [SLOT_W-1:0] age_d [ENTRIES];
  logic [ENTRIES-1:0] oldest_vec;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      age_d[i] = age_q[i];
      if (touch_en) begin
        if (SLOT_W'(i) == touch_slot)        age_d[i] = '0;
        else if (age_q[i] < age_q[touch_slot]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        age_q[g] <= SLOT_W'(g);
        else if (touch_en) age_q[g] <= age_d[g];
      end
      assign oldest_vec[g] = (age_q[g] == OLDEST);
    end
  endgenerate

  always_comb begin
    lru_slot = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (oldest_vec[i]) lru_slot = SLOT_W'(i);
  end

  // R7: ages stay a permutation, so exactly one entry is the oldest
  assert_single_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/vc_victim_store.sv
module vc_victim_store #(
  parameter int ENTRIES = 4,
  parameter int SLOT_W  = 2,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic              hit_dirty,
  output logic [DATA_W-1:0] hit_data,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              alloc_valid,
  output logic              alloc_dirty,
  output logic [ADDR_W-1:0] alloc_addr,
  output logic [DATA_W-1:0] alloc_data,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] dirty_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic [SLOT_W-1:0]  lru_slot;
  logic               any_free;
  logic [SLOT_W-1:0]  free_slot;

  vc_age_lru #(.ENTRIES(ENTRIES), .SLOT_W(SLOT_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (wr_en && wr_valid),
    .touch_slot (wr_slot),
    .lru_slot   (lru_slot)
  );

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = valid_q[g] && (addr_q[g] == lk_addr);
    end
  endgenerate

  always_comb begin
    hit_slot  = '0;
    free_slot = '0;
    any_free  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_slot = SLOT_W'(i);
      if (!valid_q[i]) begin
        free_slot = SLOT_W'(i);
        any_free  = 1'b1;
      end
    end
  end

  assign hit        = |match_vec;
  assign hit_dirty  = dirty_q[hit_slot];
  assign hit_data   = data_q[hit_slot];
  assign alloc_slot = any_free ? free_slot : lru_slot;
  assign alloc_valid = valid_q[alloc_slot];
  assign alloc_dirty = dirty_q[alloc_slot];
  assign alloc_addr  = addr_q[alloc_slot];
  assign alloc_data  = data_q[alloc_slot];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_slot] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      dirty_q[wr_slot] <= wr_dirty;
      addr_q[wr_slot]  <= wr_addr;
      data_q[wr_slot]  <= wr_data;
    end
  end

  // R4: a line address is never held by two victim entries
  assert_no_duplicate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/victim_backed_cache.sv
module victim_backed_cache
  import vcache_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int SETS    = 16,
  parameter int VICTIMS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [DATA_W-1:0] mem_resp_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int SLOT_W = (VICTIMS > 1) ? $clog2(VICTIMS) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  ctl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] miss_addr_q, miss_addr_d;
  logic              wb_valid_q, wb_valid_d;
  logic [ADDR_W-1:0] wb_addr_q, wb_addr_d;
  logic [DATA_W-1:0] wb_data_q, wb_data_d;

  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              p_valid, p_dirty, p_hit;
  logic [TAG_W-1:0]  p_tag;
  logic [DATA_W-1:0] p_data;

  logic              pw_en, pw_valid, pw_dirty;
  logic [IDX_W-1:0]  pw_idx;
  logic [TAG_W-1:0]  pw_tag;
  logic [DATA_W-1:0] pw_data;

  logic              v_hit, v_hit_dirty;
  logic [SLOT_W-1:0] v_hit_slot, v_alloc_slot;
  logic [DATA_W-1:0] v_hit_data, v_alloc_data;
  logic              v_alloc_valid, v_alloc_dirty;
  logic [ADDR_W-1:0] v_alloc_addr;
  logic              vw_en, vw_valid, vw_dirty;
  logic [SLOT_W-1:0] vw_slot;
  logic [ADDR_W-1:0] vw_addr;
  logic [DATA_W-1:0] vw_data;
  logic [ADDR_W-1:0] v_hit_addr;

  assign cur_idx    = cpu_addr[IDX_W-1:0];
  assign cur_tag    = cpu_addr[ADDR_W-1:IDX_W];
  assign v_hit_addr = cpu_addr;

  vc_line_array #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .rd_idx   (cur_idx),
    .rd_valid (p_valid),
    .rd_dirty (p_dirty),
    .rd_tag   (p_tag),
    .rd_data  (p_data),
    .wr_en    (pw_en),
    .wr_idx   (pw_idx),
    .wr_valid (pw_valid),
    .wr_dirty (pw_dirty),
    .wr_tag   (pw_tag),
    .wr_data  (pw_data)
  );

  vc_victim_store #(.ENTRIES(VICTIMS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_victims (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .lk_addr     (cpu_addr),
    .hit         (v_hit),
    .hit_slot    (v_hit_slot),
    .hit_dirty   (v_hit_dirty),
    .hit_data    (v_hit_data),
    .alloc_slot  (v_alloc_slot),
    .alloc_valid (v_alloc_valid),
    .alloc_dirty (v_alloc_dirty),
    .alloc_addr  (v_alloc_addr),
    .alloc_data  (v_alloc_data),
    .wr_en       (vw_en),
    .wr_slot     (vw_slot),
    .wr_valid    (vw_valid),
    .wr_dirty    (vw_dirty),
    .wr_addr     (vw_addr),
    .wr_data     (vw_data)
  );

  assign p_hit = cpu_valid && p_valid && (p_tag == cur_tag);

  always_comb begin
    state_d       = state_q;
    miss_addr_d   = miss_addr_q;
    wb_valid_d    = 1'b0;
    wb_addr_d     = wb_addr_q;
    wb_data_d     = wb_data_q;
    cpu_ready     = 1'b0;
    mem_req_valid = 1'b0;
    pw_en    = 1'b0;
    pw_idx   = cur_idx;
    pw_valid = 1'b1;
    pw_dirty = 1'b0;
    pw_tag   = cur_tag;
    pw_data  = cpu_wdata;
    vw_en    = 1'b0;
    vw_slot  = v_hit_slot;
    vw_valid = p_valid;
    vw_dirty = p_dirty;
    vw_addr  = {p_tag, cur_idx};
    vw_data  = p_data;
    unique case (state_q)
      ST_IDLE: begin
        if (p_hit) begin
          cpu_ready = 1'b1;
          if (cpu_write) begin
            pw_en    = 1'b1;
            pw_dirty = 1'b1;
          end
        end else if (cpu_valid && v_hit) begin
          // swap: victim line up, primary line down into the same entry
          pw_en    = 1'b1;
          pw_dirty = v_hit_dirty;
          pw_tag   = v_hit_addr[ADDR_W-1:IDX_W];
          pw_data  = v_hit_data;
          vw_en    = 1'b1;
        end else if (cpu_valid) begin
          state_d     = ST_REQ;
          miss_addr_d = cpu_addr;
          if (p_valid) begin
            vw_en    = 1'b1;
            vw_slot  = v_alloc_slot;
            pw_en    = 1'b1;
            pw_valid = 1'b0;
            pw_tag   = p_tag;
            pw_data  = p_data;
            if (v_alloc_valid && v_alloc_dirty) begin
              wb_valid_d = 1'b1;
              wb_addr_d  = v_alloc_addr;
              wb_data_d  = v_alloc_data;
            end
          end
        end
      end
      ST_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_resp_valid) begin
          pw_en   = 1'b1;
          pw_idx  = miss_addr_q[IDX_W-1:0];
          pw_tag  = miss_addr_q[ADDR_W-1:IDX_W];
          pw_data = mem_resp_data;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q    <= ST_IDLE;
      wb_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      wb_valid_q <= wb_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE) miss_addr_q <= miss_addr_d;
    if (wb_valid_d) begin
      wb_addr_q <= wb_addr_d;
      wb_data_q <= wb_data_d;
    end
  end

  assign cpu_rdata    = p_data;
  assign mem_req_addr = miss_addr_q;
  assign wb_valid     = wb_valid_q;
  assign wb_addr      = wb_addr_q;
  assign wb_data      = wb_data_q;

  // R5: a refill request is held with a stable address until accepted
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R5: no completion while a refill is pending
  assert_stall_on_refill_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q != ST_IDLE) |-> !cpu_ready);

  // R3: a victim hit resolves locally, with no refill request after it
  assert_swap_no_refill_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == ST_IDLE && cpu_valid && !p_hit && v_hit) |=> (!mem_req_valid && state_q == ST_IDLE));

  // R8: a writeback lasts a single cycle
  assert_wb_pulse_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    wb_valid |=> !wb_valid);
endmodule

// File: tb/victim_backed_cache_tb.sv
module victim_backed_cache_tb;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int SETS    = 16;
  localparam int VICTIMS = 4;
  localparam int IDX_W   = $clog2(SETS);

  localparam int C_HIT  = 0;
  localparam int C_VHIT = 1;
  localparam int C_MISS = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cpu_valid, cpu_write;
  logic [ADDR_W-1:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata;
  logic              cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic              mem_req_valid, mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_resp_valid;
  logic [DATA_W-1:0] mem_resp_data;
  logic              wb_valid;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;

  always #10 clk = ~clk;

  victim_backed_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .VICTIMS(VICTIMS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  bit          pv [SETS];
  int          pline [SETS];
  bit          pd [SETS];
  int          vaddr_q[$];
  bit          vdirty_q[$];
  logic [31:0] ref_mem [int];
  logic [31:0] mem_model [int];
  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  int          wb_exp_q[$];
  int          miss_exp_q[$];
  int          req_seen = 0;
  int          miss_count = 0;

  function automatic logic [31:0] seed_val(int a);
    return 32'hA500_0000 ^ (a * 32'h0000_9E37);
  endfunction

  function automatic logic [31:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_val(a);
  endfunction

  function automatic logic [31:0] mem_rd(int a);
    return mem_model.exists(a) ? mem_model[a] : seed_val(a);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // classify and update the model; returns the class
  function automatic int model_step(int a, bit w);
    int idx = a % SETS;
    int pos = -1;
    bit dv;
    int ea;
    bit ed;
    if (pv[idx] && pline[idx] == a) begin
      pd[idx] = pd[idx] | w;
      return C_HIT;
    end
    foreach (vaddr_q[i]) if (vaddr_q[i] == a) pos = i;
    if (pos >= 0) begin
      dv = vdirty_q[pos];
      vaddr_q.delete(pos);
      vdirty_q.delete(pos);
      if (pv[idx]) begin
        vaddr_q.push_front(pline[idx]);
        vdirty_q.push_front(pd[idx]);
      end
      pv[idx] = 1'b1; pline[idx] = a; pd[idx] = dv | w;
      return C_VHIT;
    end
    if (pv[idx]) begin
      vaddr_q.push_front(pline[idx]);
      vdirty_q.push_front(pd[idx]);
      if (vaddr_q.size() > VICTIMS) begin
        ea = vaddr_q.pop_back();
        ed = vdirty_q.pop_back();
        if (ed) wb_exp_q.push_back(ea);
      end
    end
    pv[idx] = 1'b1; pline[idx] = a; pd[idx] = w;
    return C_MISS;
  endfunction

  // driver: predicts, pushes expectations, presents the request
  task automatic access(input int a, input bit w, input logic [31:0] d, input string rq);
    int cls;
    int waited;
    cls = model_step(a, w);
    if (cls == C_MISS) begin
      miss_exp_q.push_back(a);
      miss_count++;
    end
    if (w) ref_mem[a] = d;
    else begin
      rd_exp_q.push_back(ref_rd(a));
      rd_tag_q.push_back(rq);
    end
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = w; cpu_addr = ADDR_W'(a); cpu_wdata = d;
    waited = 0;
    #1;
    while (!cpu_ready && waited < 200) begin
      @(negedge clk); #1;
      waited++;
    end
    case (cls)
      C_HIT:  check(waited == 0, "R1", "primary hit latency", waited, 0);
      C_VHIT: check(waited == 1, "R3", "victim hit latency", waited, 1);
      default: check(waited >= 3 && waited < 200, "R5", "full miss latency", waited, 3);
    endcase
    @(posedge clk); #1;
    cpu_valid = 1'b0;
  endtask

  // monitor: read data against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (cpu_valid && cpu_ready && !cpu_write) begin
        if (rd_exp_q.size() == 0) check(1'b0, "R2", "unexpected read completion", cpu_rdata, 0);
        else begin
          automatic logic [31:0] e = rd_exp_q.pop_front();
          automatic string t = rd_tag_q.pop_front();
          check(cpu_rdata == e, t, "read data", cpu_rdata, e);
        end
      end
    end
  end

  // next-level memory model
  initial begin
    mem_resp_valid = 1'b0;
    mem_resp_data  = '0;
    mem_req_ready  = 1'b1;
    forever begin
      @(negedge clk); #2;
      if (mem_req_valid) begin
        automatic int ra = int'(mem_req_addr);
        automatic int ea = (miss_exp_q.size() > 0) ? miss_exp_q.pop_front() : -1;
        req_seen++;
        check(ra == ea, "R5", "refill address", ra, ea);
        repeat (3) @(negedge clk);
        mem_resp_valid = 1'b1;
        mem_resp_data  = mem_rd(ra);
        @(negedge clk);
        mem_resp_valid = 1'b0;
      end
    end
  end

  // writeback monitor
  initial begin
    forever begin
      @(negedge clk); #2;
      if (wb_valid) begin
        automatic int wa = int'(wb_addr);
        automatic int ea = (wb_exp_q.size() > 0) ? wb_exp_q.pop_front() : -1;
        check(wa == ea, "R8", "writeback address", wa, ea);
        check(wb_data == ref_rd(wa), "R8", "writeback data", wb_data, ref_rd(wa));
        mem_model[wa] = wb_data;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    cpu_valid = 1'b0; cpu_write = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9: idle outputs after reset
    check(!cpu_ready && !mem_req_valid && !wb_valid, "R9", "outputs after reset",
          {cpu_ready, mem_req_valid, wb_valid}, 0);

    // R9 / R1 / R2: cold miss, hit, write hit, reread
    access(12'h013, 0, 0, "R9");
    access(12'h013, 0, 0, "R1");
    access(12'h013, 1, 32'hCAFE_0013, "R2");
    access(12'h013, 0, 0, "R2");

    // R6 / R3 / R4: conflict, displaced line reached through the victim buffer
    access(12'h023, 0, 0, "R6");
    access(12'h013, 0, 0, "R3");
    access(12'h023, 0, 0, "R4");
    access(12'h013, 1, 32'hBEEF_1313, "R4");

    // R7 / R8: overflow the victim buffer at index 5 with dirty and clean lines
    for (int k = 1; k <= 6; k++) begin
      access((k << IDX_W) | 5, (k % 2) == 1, 32'h5500_0000 + k, "R8");
    end
    access((2 << IDX_W) | 5, 0, 0, "R7");
    for (int k = 7; k <= 9; k++) access((k << IDX_W) | 5, 1, 32'h7700_0000 + k, "R7");
    for (int k = 1; k <= 9; k++) access((k << IDX_W) | 5, 0, 0, "R7");

    // R10 / R2: pseudo-random mix over a few indices
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      automatic int a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = ((lfsr[6:4]) << IDX_W) | lfsr[1:0];
      access(a, lfsr[9] & lfsr[8], {16'h0, lfsr}, "R10");
    end

    repeat (10) @(negedge clk);
    check(req_seen == miss_count, "R5", "one refill per miss", req_seen, miss_count);
    check(wb_exp_q.size() == 0, "R8", "expected writebacks left", wb_exp_q.size(), 0);
    check(rd_exp_q.size() == 0, "R2", "reads left unanswered", rd_exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule